// File: doc/BRIEF.md
# Wake-Up Event Interrupt Controller

This block gathers attention events from five places: an external active-low pulse input, a wake-up timer expiry strobe, a low-supply detection strobe, a receive-FIFO fill-level strobe and a request strobe from the host serial engine. Each event is latched in a sticky status bit. A single active-low interrupt request tells the host that at least one enabled source is pending. Each source can be switched off on its own. A disabled source cannot latch, and a bit that is already set stops contributing to the request while its source is disabled.

The host reads the sources through a small read state machine with two states. `RD_IDLE` waits and moves to `RD_SNAP` when `rd_req` is sampled high. In `RD_SNAP` it presents a snapshot of the status, raises `rd_valid` for exactly one cycle, clears the returned bits at the end of that cycle, and always goes back to `RD_IDLE`. The external input is asynchronous and passes through a two-flop synchronizer and a falling-edge detector. The timer, comparator and serial engine are outside this block; it sees only their single-cycle strobes.

Top module: `wk_irq_ctrl`

## Requirements
- R1: After reset all status bits are clear, `irq_n` is 1, `rd_valid` is 0 and `rd_data` is 0.
- R2: A falling edge on `ext_int_n` sets status bit 0, which is visible at `irq_n` within four cycles. Holding the input low does not set the bit again after a read, and a rising edge sets nothing.
- R3: A one-cycle high strobe on `tmr_evt`, `lowv_evt`, `fifo_evt` or `host_evt` sets status bit 1, 2, 3 or 4 respectively on the next clock edge.
- R4: A set status bit stays set, whatever the time elapsed, until a status read returns it.
- R5: An event whose `src_en` bit is 0 does not set its status bit.
- R6: `irq_n` is 0 exactly when some status bit is set while its `src_en` bit is 1. Clearing an enable raises `irq_n` without losing the pending bit.
- R7: When `rd_req` is sampled high in `RD_IDLE`, `rd_valid` is 1 in the next cycle only. In that cycle `rd_data` holds the status as it was at the sampling edge, with bit order {host, fifo, lowv, tmr, ext}.
- R8: At the end of the `rd_valid` cycle the returned bits are cleared. A following read returns 0 unless new events have arrived.
- R9: An enabled event that arrives during the `rd_valid` cycle remains set after the clear.
- R10: `rd_req` sampled high while in `RD_SNAP` is ignored; no second `rd_valid` cycle follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_int_n | input | 1 | Asynchronous external event input, active low |
| tmr_evt | input | 1 | Wake-up timer expiry strobe |
| lowv_evt | input | 1 | Low-supply detection strobe |
| fifo_evt | input | 1 | Receive FIFO fill-level strobe |
| host_evt | input | 1 | Host request strobe |
| src_en | input | 5 | Per-source enable, same bit order as status |
| rd_req | input | 1 | Status read request |
| irq_n | output | 1 | Interrupt request, active low |
| rd_valid | output | 1 | Snapshot valid, one cycle |
| rd_data | output | 5 | Snapshot of status bits |

## Verification
The strobe properties assume that each event input is a clean single-cycle pulse that is synchronous to `clk`. They tolerate an enable that drops in the following cycle, because a dropped enable legitimately releases the request. The bench drives all strobes and `rd_req` on the falling clock edge and holds each strobe for one cycle only. It changes `ext_int_n` only with several cycles of settling time, so the synchronizer latency is the same on every run. The sweep covers all 32 enable masks against all 32 event patterns and predicts both the request level and the snapshot as the bitwise AND of pattern and mask.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int NUM_SRC  = 5;
    localparam int SRC_EXT  = 0;
    localparam int SRC_TMR  = 1;
    localparam int SRC_LOWV = 2;
    localparam int SRC_FIFO = 3;
    localparam int SRC_HOST = 4;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_SNAP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/wk_edge_sync.sv
module wk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic fall_pls
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         hist_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= async_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[TOP-1:0], async_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b1;
        else        hist_q <= chain_q[TOP];
    end

    assign fall_pls = hist_q & ~chain_q[TOP];
endmodule

// File: rtl/wk_status.sv
module wk_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);
    logic [N-1:0] stat_q;
    logic [N-1:0] stat_d;

    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            // set has priority over clear
            assign stat_d[g] = (evt[g] & en[g]) | (stat_q[g] & ~clr[g]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;
endmodule

// File: rtl/wk_read_fsm.sv
module wk_read_fsm
    import wk_pkg::*;
#(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_req,
    input  logic [N-1:0] stat,
    output logic         rd_valid,
    output logic [N-1:0] rd_data,
    output logic [N-1:0] clr
);
    rd_state_e    state_q;
    rd_state_e    state_d;
    logic [N-1:0] snap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_req) state_d = RD_SNAP;
            RD_SNAP: state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // state register and snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RD_IDLE && rd_req) snap_q <= stat;
        end
    end

    // outputs
    always_comb begin
        rd_valid = 1'b0;
        clr      = '0;
        unique case (state_q)
            RD_IDLE: ;
            RD_SNAP: begin
                rd_valid = 1'b1;
                clr      = snap_q;
            end
            default: ;
        endcase
    end

    assign rd_data = snap_q;
endmodule

// File: rtl/wk_irq_ctrl.sv
module wk_irq_ctrl
    import wk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int W = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_int_n,
    input  logic         tmr_evt,
    input  logic         lowv_evt,
    input  logic         fifo_evt,
    input  logic         host_evt,
    input  logic [W-1:0] src_en,
    input  logic         rd_req,
    output logic         irq_n,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    logic         ext_fall;
    logic [W-1:0] evt_vec;
    logic [W-1:0] stat;
    logic [W-1:0] clr;

    wk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_n  (ext_int_n),
        .fall_pls (ext_fall)
    );

    always_comb begin
        evt_vec           = '0;
        evt_vec[SRC_EXT]  = ext_fall;
        evt_vec[SRC_TMR]  = tmr_evt;
        evt_vec[SRC_LOWV] = lowv_evt;
        evt_vec[SRC_FIFO] = fifo_evt;
        evt_vec[SRC_HOST] = host_evt;
    end

    wk_status #(.N(W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_vec),
        .en    (src_en),
        .clr   (clr),
        .stat  (stat)
    );

    wk_read_fsm #(.N(W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .stat     (stat),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .clr      (clr)
    );

    assign irq_n = ~|(stat & src_en);
endmodule

// File: rtl/wk_irq_ctrl_chk.sv
module wk_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_evt,
    input logic       lowv_evt,
    input logic       fifo_evt,
    input logic       host_evt,
    input logic [4:0] src_en,
    input logic       rd_req,
    input logic       irq_n,
    input logic       rd_valid
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_n && !rd_valid));

    // R3
    tmr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_evt && src_en[1]) |=> (!irq_n || !src_en[1]));

    // R3
    lowv_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lowv_evt && src_en[2]) |=> (!irq_n || !src_en[2]));

    // R3
    host_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_evt && src_en[4]) |=> (!irq_n || !src_en[4]));

    // R5
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == 5'd0) |-> irq_n);

    // R7
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> rd_valid);

    // R7
    rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R9
    fifo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && fifo_evt && src_en[3]) |=> (!irq_n || !src_en[3]));
endmodule

bind wk_irq_ctrl wk_irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_evt  (tmr_evt),
    .lowv_evt (lowv_evt),
    .fifo_evt (fifo_evt),
    .host_evt (host_evt),
    .src_en   (src_en),
    .rd_req   (rd_req),
    .irq_n    (irq_n),
    .rd_valid (rd_valid)
);

// File: tb/wk_irq_ctrl_bench.sv
module wk_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_int_n = 1'b1;
    logic       tmr_evt = 1'b0;
    logic       lowv_evt = 1'b0;
    logic       fifo_evt = 1'b0;
    logic       host_evt = 1'b0;
    logic [4:0] src_en = 5'd0;
    logic       rd_req = 1'b0;
    logic       irq_n;
    logic       rd_valid;
    logic [4:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wk_irq_ctrl u_wk_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_int_n(ext_int_n),
        .tmr_evt(tmr_evt), .lowv_evt(lowv_evt), .fifo_evt(fifo_evt),
        .host_evt(host_evt), .src_en(src_en), .rd_req(rd_req),
        .irq_n(irq_n), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // issue a read; returns valid flag and data sampled in the valid cycle
    task automatic do_read(output logic v, output logic [4:0] d);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        v = rd_valid;
        d = rd_data;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       v;
        logic [4:0] d;

        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 rd_data", rd_data, 0);
        src_en = 5'h1F;
        do_read(v, d);
        chk("R1 status", d, 0);

        // near-exhaustive sweep: enable mask x event pattern
        for (int m = 0; m < 32; m++) begin
            for (int p = 0; p < 32; p++) begin
                logic [4:0] exp_v;
                exp_v = 5'(p) & 5'(m);
                src_en = 5'(m);
                @(negedge clk);
                ext_int_n = ~p[0];
                tmr_evt   = p[1];
                lowv_evt  = p[2];
                fifo_evt  = p[3];
                host_evt  = p[4];
                @(negedge clk);
                tmr_evt = 0; lowv_evt = 0; fifo_evt = 0; host_evt = 0;
                wait_n(3);
                // R6 R2 R3 R5
                chk("R6 sweep irq_n", irq_n, (exp_v == 0));
                ext_int_n = 1'b1;
                wait_n(4);
                do_read(v, d);
                chk("R7 sweep valid", v, 1);
                // R2 R3 R5 R7
                chk("R7 sweep data", d, exp_v);
                chk("R8 sweep cleared irq", irq_n, 1);
                do_read(v, d);
                chk("R8 sweep reread", d, 0);
            end
        end

        src_en = 5'h1F;
        // R4 sticky over a long wait
        @(negedge clk) tmr_evt = 1;
        @(negedge clk) tmr_evt = 0;
        wait_n(40);
        chk("R4 irq held", irq_n, 0);
        do_read(v, d);
        chk("R4 data", d, 5'b00010);

        // R2 held low, no retrigger; rising edge no event
        @(negedge clk) ext_int_n = 0;
        wait_n(5);
        do_read(v, d);
        chk("R2 first fall", d, 5'b00001);
        wait_n(5);
        do_read(v, d);
        chk("R2 held low", d, 0);
        chk("R2 held low irq", irq_n, 1);
        ext_int_n = 1;
        wait_n(5);
        do_read(v, d);
        chk("R2 rising", d, 0);

        // R6 disabling a pending source
        @(negedge clk) host_evt = 1;
        @(negedge clk) host_evt = 0;
        chk("R6 pending", irq_n, 0);
        src_en = 5'b01111;
        @(negedge clk);
        chk("R6 masked", irq_n, 1);
        src_en = 5'h1F;
        @(negedge clk);
        chk("R6 unmasked", irq_n, 0);
        do_read(v, d);
        chk("R6 kept bit", d, 5'b10000);

        // R9 event during the clear cycle
        @(negedge clk) fifo_evt = 1;
        @(negedge clk) fifo_evt = 0;
        rd_req = 1;
        @(negedge clk) rd_req = 0;
        fifo_evt = 1;
        chk("R9 valid", rd_valid, 1);
        chk("R9 data", rd_data, 5'b01000);
        @(negedge clk) fifo_evt = 0;
        chk("R9 irq kept", irq_n, 0);
        do_read(v, d);
        chk("R9 reread", d, 5'b01000);

        // R10 request held during the valid cycle
        @(negedge clk) rd_req = 1;
        @(negedge clk);
        chk("R10 first valid", rd_valid, 1);
        @(negedge clk) rd_req = 0;
        chk("R10 no second valid", rd_valid, 0);
        wait_n(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule